// File: doc/BRIEF.md
# Interrupt Register Bank Stack Controller

This block keeps a last-in, first-out stack of register banks. A CPU uses it to save and restore its working context quickly around an interrupt. When the CPU accepts an interrupt that is marked for bank use, the controller copies a snapshot of nineteen 32-bit registers into the next free bank. These are fifteen general-purpose registers, the global base register, the two multiply-accumulate halves and the procedure return register. A restore command takes the most recently filled bank, releases it, and presents its contents on a restore bus with a one-cycle write enable, so the register file can reload from it.

The controller tracks how many banks are in use, up to a limit of fifteen. It refuses a save when every bank is full and a restore when none is in use. An overflow, meaning a save into a full stack, is reported only when software has enabled overflow reporting; otherwise the save is dropped silently. An underflow, meaning a restore from an empty stack, is always reported. In both error cases the bank count and the stored banks are left exactly as they were. Every accepted command finishes in one clock cycle, and a registered done pulse follows it on the next cycle.

Top module: `rbank_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `bank_count` to 0 and holds `save_done`, `restore_done`, `restore_we` and `bank_err` low in the cycle after that edge.
- R2: A save command (`irq_accept`=1 and `irq_bank_en`=1) with `bank_count` below 15 stores `snap_regs` into bank number `bank_count` and increments `bank_count` by one. Both results are visible one cycle after the command edge.
- R3: `irq_accept` with `irq_bank_en`=0 saves nothing, leaves `bank_count` unchanged and produces no `save_done` and no error.
- R4: A restore command (`restore_cmd`=1) with `bank_count` above 0 decrements `bank_count`. One cycle after the command edge, `restore_regs` carries the most recently saved bank that is still held, and `restore_we` is high for exactly that one cycle. Banks therefore come back in last-in, first-out order.
- R5: A save command with `bank_count`=15 and `ovf_exc_en`=1 pulses `bank_err` for one cycle with `bank_err_cause`=0. `bank_count` stays at 15, and the bank contents are not changed, so a later restore returns the data of the fifteenth successful save.
- R6: A save command with `bank_count`=15 and `ovf_exc_en`=0 is dropped: `bank_count` stays at 15 and `bank_err` stays low.
- R7: A restore command with `bank_count`=0 always pulses `bank_err` with `bank_err_cause`=1, keeps `restore_we` low and leaves `bank_count` at 0.
- R8: When a save command and a restore command arrive in the same cycle, only the save is performed, and the restore is ignored with no `restore_done`.
- R9: `save_done` pulses for one cycle after every save command, whether it is stored, dropped or reported. `restore_done` pulses for one cycle after every restore command that is performed or reported as underflow.
- R10: The error cause encoding is 0 for overflow and 1 for underflow. `bank_err` is high for only one cycle per faulting command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_accept | input | 1 | CPU has accepted an interrupt this cycle |
| irq_bank_en | input | 1 | Bank use enabled for the accepted interrupt |
| ovf_exc_en | input | 1 | Report overflow as an error when set |
| restore_cmd | input | 1 | Restore the most recent bank |
| snap_regs | input | 608 | Register-file snapshot, word w at bits [32w+31:32w] |
| bank_count | output | 4 | Number of banks in use |
| save_done | output | 1 | One-cycle completion pulse for a save command |
| restore_done | output | 1 | One-cycle completion pulse for a restore command |
| restore_we | output | 1 | Register-file write enable for the restore bus |
| restore_regs | output | 608 | Restored register words, same layout as snap_regs |
| bank_err | output | 1 | One-cycle bank error request |
| bank_err_cause | output | 1 | 0 overflow, 1 underflow |

## Verification
The bench fills the stack to fifteen and then pushes against the full stack, once with overflow reporting off and once with it on. A design that wraps the count, overwrites the top bank, or reports the error regardless of the enable would show a wrong count, a spurious pulse, or the wrong data on the next restore. A restore on an empty stack must raise the underflow cause without a write enable; a design that decrements to fifteen or writes stale data would fail there. Simultaneous save and restore, a save without bank use, and draining fifteen banks in reverse order check the priority rule and the LIFO ordering.

// File: rtl/rbk_pkg.sv
package rbk_pkg;

    // Error cause carried on the error request
    typedef enum logic {
        CAUSE_OVF = 1'b0,
        CAUSE_UNF = 1'b1
    } err_cause_e;

    // Decoded action for the current cycle
    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_SAVE     = 3'd1,
        OP_OVF_ERR  = 3'd2,
        OP_OVF_DROP = 3'd3,
        OP_RESTORE  = 3'd4,
        OP_UNF_ERR  = 3'd5
    } bank_op_e;

endpackage

// File: rtl/rbk_cmd.sv
module rbk_cmd
    import rbk_pkg::*;
(
    input  logic     save_req,
    input  logic     bank_use,
    input  logic     ovf_en,
    input  logic     rest_req,
    input  logic     full,
    input  logic     empty,
    output bank_op_e op
);

    logic do_save;

    assign do_save = save_req && bank_use;

    always_comb begin
        op = OP_IDLE;
        if (do_save) begin
            if (!full)       op = OP_SAVE;
            else if (ovf_en) op = OP_OVF_ERR;
            else             op = OP_OVF_DROP;
        end else if (rest_req) begin
            if (!empty)      op = OP_RESTORE;
            else             op = OP_UNF_ERR;
        end
    end

endmodule

// File: rtl/rbk_store.sv
module rbk_store #(
    parameter int NUM_BANKS = 15,
    parameter int WORDS     = 19,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = WORDS * DATA_W,
    localparam int IDX_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_data
);

    logic [LINE_W-1:0] line_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [LINE_W-1:0] line_d;

        always_comb begin
            line_d = line_q[b];
            if (wr_en && (wr_idx == IDX_W'(b))) line_d = wr_data;
        end

        always_ff @(posedge clk) begin
            line_q[b] <= line_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_idx == IDX_W'(b)) rd_data = line_q[b];
        end
    end

endmodule

// File: rtl/rbk_ctrl.sv
module rbk_ctrl
    import rbk_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int WORDS     = 19,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = WORDS * DATA_W,
    localparam int IDX_W    = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_op_e          op,
    input  logic [LINE_W-1:0] rd_data,
    output logic              full,
    output logic              empty,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  count,
    output logic              save_done,
    output logic              rest_done,
    output logic              rest_we,
    output logic [LINE_W-1:0] rest_data,
    output logic              err,
    output logic              err_cause
);

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic              save_done;
        logic              rest_done;
        logic              rest_we;
        logic              err;
        logic              cause;
        logic [LINE_W-1:0] rest_data;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] below;

    assign full   = (st_q.count == CNT_W'(NUM_BANKS));
    assign empty  = (st_q.count == '0);
    assign below  = st_q.count - CNT_W'(1);
    assign wr_idx = IDX_W'(st_q.count);
    assign rd_idx = IDX_W'(below);
    assign wr_en  = (op == OP_SAVE);

    always_comb begin
        st_d           = st_q;
        st_d.save_done = 1'b0;
        st_d.rest_done = 1'b0;
        st_d.rest_we   = 1'b0;
        st_d.err       = 1'b0;
        unique case (op)
            OP_SAVE: begin
                st_d.count     = st_q.count + CNT_W'(1);
                st_d.save_done = 1'b1;
            end
            OP_OVF_ERR: begin
                st_d.save_done = 1'b1;
                st_d.err       = 1'b1;
                st_d.cause     = CAUSE_OVF;
            end
            OP_OVF_DROP: begin
                st_d.save_done = 1'b1;
            end
            OP_RESTORE: begin
                st_d.count     = below;
                st_d.rest_done = 1'b1;
                st_d.rest_we   = 1'b1;
                st_d.rest_data = rd_data;
            end
            OP_UNF_ERR: begin
                st_d.rest_done = 1'b1;
                st_d.err       = 1'b1;
                st_d.cause     = CAUSE_UNF;
            end
            default: ;
        endcase
        if (rst) begin
            st_d.count     = '0;
            st_d.save_done = 1'b0;
            st_d.rest_done = 1'b0;
            st_d.rest_we   = 1'b0;
            st_d.err       = 1'b0;
            st_d.cause     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count     = st_q.count;
    assign save_done = st_q.save_done;
    assign rest_done = st_q.rest_done;
    assign rest_we   = st_q.rest_we;
    assign rest_data = st_q.rest_data;
    assign err       = st_q.err;
    assign err_cause = st_q.cause;

endmodule

// File: rtl/rbank_ctrl.sv
module rbank_ctrl
    import rbk_pkg::*;
#(
    parameter int NUM_BANKS = 15,
    parameter int WORDS     = 19,
    parameter int DATA_W    = 32,
    localparam int LINE_W   = WORDS * DATA_W,
    localparam int IDX_W    = $clog2(NUM_BANKS),
    localparam int CNT_W    = $clog2(NUM_BANKS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_accept,
    input  logic              irq_bank_en,
    input  logic              ovf_exc_en,
    input  logic              restore_cmd,
    input  logic [LINE_W-1:0] snap_regs,
    output logic [CNT_W-1:0]  bank_count,
    output logic              save_done,
    output logic              restore_done,
    output logic              restore_we,
    output logic [LINE_W-1:0] restore_regs,
    output logic              bank_err,
    output logic              bank_err_cause
);

    bank_op_e          op;
    logic              full, empty, wr_en;
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic [LINE_W-1:0] rd_data;

    rbk_cmd u_cmd (
        .save_req (irq_accept),
        .bank_use (irq_bank_en),
        .ovf_en   (ovf_exc_en),
        .rest_req (restore_cmd),
        .full     (full),
        .empty    (empty),
        .op       (op)
    );

    rbk_store #(
        .NUM_BANKS (NUM_BANKS),
        .WORDS     (WORDS),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (snap_regs),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    rbk_ctrl #(
        .NUM_BANKS (NUM_BANKS),
        .WORDS     (WORDS),
        .DATA_W    (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .rd_data   (rd_data),
        .full      (full),
        .empty     (empty),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .count     (bank_count),
        .save_done (save_done),
        .rest_done (restore_done),
        .rest_we   (restore_we),
        .rest_data (restore_regs),
        .err       (bank_err),
        .err_cause (bank_err_cause)
    );

endmodule

// File: rtl/rbank_chk.sv
module rbank_chk #(
    parameter int NUM_BANKS = 15,
    localparam int CNT_W    = $clog2(NUM_BANKS + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             irq_accept,
    input logic             irq_bank_en,
    input logic             ovf_exc_en,
    input logic             restore_cmd,
    input logic [CNT_W-1:0] bank_count,
    input logic             save_done,
    input logic             restore_done,
    input logic             restore_we,
    input logic             bank_err,
    input logic             bank_err_cause
);

    logic sv, full;
    assign sv   = irq_accept && irq_bank_en;
    assign full = (bank_count == CNT_W'(NUM_BANKS));

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (bank_count == '0) && !bank_err && !restore_we);

    a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
        (sv && !full) |=> (bank_count == $past(bank_count) + CNT_W'(1)));

    a_r3_no_bank_use: assert property (@(posedge clk) disable iff (rst)
        (irq_accept && !irq_bank_en && !restore_cmd)
            |=> (bank_count == $past(bank_count)) && !save_done && !bank_err);

    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (!sv && restore_cmd && bank_count != '0)
            |=> restore_we && (bank_count == $past(bank_count) - CNT_W'(1)));

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (sv && full && ovf_exc_en)
            |=> full && bank_err && !bank_err_cause);

    a_r6_silent_drop: assert property (@(posedge clk) disable iff (rst)
        (sv && full && !ovf_exc_en) |=> full && !bank_err);

    a_r7_underflow: assert property (@(posedge clk) disable iff (rst)
        (!sv && restore_cmd && bank_count == '0)
            |=> bank_err && bank_err_cause && !restore_we && (bank_count == '0));

    a_r8_save_wins: assert property (@(posedge clk) disable iff (rst)
        (sv && restore_cmd) |=> !restore_done && !restore_we);

    a_r9_we_has_done: assert property (@(posedge clk) disable iff (rst)
        restore_we |-> restore_done);

    a_r10_count_range: assert property (@(posedge clk) disable iff (rst)
        bank_count <= CNT_W'(NUM_BANKS));

endmodule

bind rbank_ctrl rbank_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .irq_accept     (irq_accept),
    .irq_bank_en    (irq_bank_en),
    .ovf_exc_en     (ovf_exc_en),
    .restore_cmd    (restore_cmd),
    .bank_count     (bank_count),
    .save_done      (save_done),
    .restore_done   (restore_done),
    .restore_we     (restore_we),
    .bank_err       (bank_err),
    .bank_err_cause (bank_err_cause)
);

// File: tb/rbank_ctrl_test.sv
`timescale 1ns/1ps
module rbank_ctrl_test;

    localparam int NB     = 15;
    localparam int WORDS  = 19;
    localparam int DW     = 32;
    localparam int LINE_W = WORDS * DW;

    typedef struct packed {
        logic       s, e, o, r;
        logic [3:0] cnt;
        logic       err, cause, we;
    } vec_t;

    // {save, bank_en, ovf_en, restore, count, err, cause, we}
    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 1'b1, 1'b0},  // R7 underflow
        '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0},  // R3 no bank use
        '{1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0},  // R2
        '{1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0},  // R2
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b1},  // R4
        '{1'b1, 1'b1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},  // R8
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b1},  // R4
        '{1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b1},  // R4
        '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0}   // idle
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              irq_accept, irq_bank_en, ovf_exc_en, restore_cmd;
    logic [LINE_W-1:0] snap_regs;
    logic [3:0]        bank_count;
    logic              save_done, restore_done, restore_we;
    logic [LINE_W-1:0] restore_regs;
    logic              bank_err, bank_err_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int mstk [16];
    int mcnt = 0;

    always #4 clk = ~clk;

    rbank_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .irq_accept     (irq_accept),
        .irq_bank_en    (irq_bank_en),
        .ovf_exc_en     (ovf_exc_en),
        .restore_cmd    (restore_cmd),
        .snap_regs      (snap_regs),
        .bank_count     (bank_count),
        .save_done      (save_done),
        .restore_done   (restore_done),
        .restore_we     (restore_we),
        .restore_regs   (restore_regs),
        .bank_err       (bank_err),
        .bank_err_cause (bank_err_cause)
    );

    function automatic logic [LINE_W-1:0] snap_of(int tag);
        logic [LINE_W-1:0] v;
        for (int w = 0; w < WORDS; w++)
            v[w*DW +: DW] = 32'hA500_0000 ^ (32'(tag) << 8) ^ 32'(w * 3 + 1);
        return v;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s got %0h exp %0h", req, what, act, exp);
        end
    endtask

    // Apply one command, then compare outputs with the bench model
    task automatic step(logic s, logic e, logic o, logic r, int tag, string req);
        logic exp_sd, exp_rd, exp_we, exp_err, exp_cause;
        int   exp_tag;
        exp_sd = 0; exp_rd = 0; exp_we = 0; exp_err = 0; exp_cause = 0; exp_tag = 0;
        irq_accept = s; irq_bank_en = e; ovf_exc_en = o; restore_cmd = r;
        snap_regs = snap_of(tag);
        if (s && e) begin
            exp_sd = 1;
            if (mcnt == NB) begin
                exp_err = o; exp_cause = 0;
            end else begin
                mstk[mcnt] = tag; mcnt++;
            end
        end else if (r) begin
            exp_rd = 1;
            if (mcnt == 0) begin
                exp_err = 1; exp_cause = 1;
            end else begin
                mcnt--; exp_we = 1; exp_tag = mstk[mcnt];
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, "bank_count", 64'(bank_count), 64'(mcnt));
        chk(req, "save_done", 64'(save_done), 64'(exp_sd));
        chk(req, "restore_done", 64'(restore_done), 64'(exp_rd));
        chk(req, "restore_we", 64'(restore_we), 64'(exp_we));
        chk(req, "bank_err", 64'(bank_err), 64'(exp_err));
        if (exp_err) chk("R10", "bank_err_cause", 64'(bank_err_cause), 64'(exp_cause));
        if (exp_we) begin
            checks++;
            if (restore_regs !== snap_of(exp_tag)) begin
                errors++;
                $display("FAIL %s: restore_regs got %0h exp %0h", req,
                         restore_regs[63:0], snap_of(exp_tag) & 64'hFFFF_FFFF_FFFF_FFFF);
            end
        end
    endtask

    task automatic idle();
        irq_accept = 0; irq_bank_en = 0; ovf_exc_en = 0; restore_cmd = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run got hung exp done");
        finish_run();
    end

    initial begin
        idle();
        snap_regs = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "bank_count", 64'(bank_count), 64'd0);
        chk("R1", "restore_we", 64'(restore_we), 64'd0);
        chk("R1", "bank_err", 64'(bank_err), 64'd0);
        chk("R1", "done pulses", 64'({save_done, restore_done}), 64'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            step(v.s, v.e, v.o, v.r, 16 + i, "table");
            chk("R2", "table count", 64'(bank_count), 64'(v.cnt));
            chk("R7", "table err", 64'(bank_err), 64'(v.err));
            if (v.err) chk("R10", "table cause", 64'(bank_err_cause), 64'(v.cause));
            chk("R4", "table we", 64'(restore_we), 64'(v.we));
        end

        // Fill to full
        for (int i = 0; i < NB; i++) step(1, 1, 0, 0, 100 + i, "R2");
        chk("R2", "full count", 64'(bank_count), 64'd15);
        // Full, overflow reporting off: silent drop
        step(1, 1, 0, 0, 200, "R6");
        chk("R6", "no err", 64'(bank_err), 64'd0);
        // Full, overflow reporting on
        step(1, 1, 1, 0, 201, "R5");
        chk("R5", "err cause", 64'({bank_err, bank_err_cause}), 64'b10);
        step(1, 1, 1, 0, 202, "R5");
        step(0, 0, 0, 0, 0, "R10");
        chk("R10", "single pulse", 64'(bank_err), 64'd0);
        // Save without bank use while full
        step(1, 0, 1, 0, 203, "R3");
        // Drain: must get 114 down to 100
        for (int i = 0; i < NB; i++) step(0, 0, 0, 1, 0, "R4");
        // Underflow at empty
        step(0, 0, 0, 1, 0, "R7");
        step(0, 0, 0, 1, 0, "R7");
        // Simultaneous at empty: save performed, no underflow
        step(1, 1, 0, 1, 300, "R8");
        step(1, 1, 0, 1, 301, "R9");
        // Reset mid run
        idle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mcnt = 0;
        chk("R1", "count after reset", 64'(bank_count), 64'd0);
        chk("R1", "pulses after reset", 64'({save_done, restore_done, restore_we, bank_err}), 64'd0);
        step(0, 0, 0, 1, 0, "R7");
        step(1, 1, 0, 0, 400, "R2");
        step(0, 0, 0, 1, 0, "R4");
        idle();
        @(negedge clk);
        finish_run();
    end

endmodule